// File: doc/BRIEF.md
# Sequencer Program Memory Loader

This block holds the instruction store of an embedded sequencer and gives a host a way to fill it and check it through one 8-bit register window. Each instruction is a 32-bit word. The host first sets a 9-bit word address. The low eight bits are held in one address register, and bit 0 of a second address register supplies the ninth. The host then streams the bytes of each word through the window. A byte-lane index tracks where the stream is within the current word. Bytes enter least significant first. The word is stored only when its last byte arrives, and at that point the address steps to the next word.

A control register holds two bits. The first enables window traffic. The second drives a level output that holds the sequencer's program counter in reset while the program is being loaded. The sequencer reads the store through its own fetch port, which has a word address input and a word output.

Window reads return the bytes of the addressed word in the same order as writes and advance the address in the same way. This lets the host verify a program it has just loaded.

Top module: `seqram_loader`

## Requirements
- R1: After a synchronous reset, the control register, both address registers and `seq_pc_rst` all read 0.
- R2: The word address is {address-high bit 0, address-low[7:0]}. Address-high reads back with bits 7 to 1 at zero, whatever value was written.
- R3: With loading enabled, four window writes place the word {b3,b2,b1,b0} at the current address, where b0 is the first byte written.
- R4: The address stays the same after the first three bytes of a word. It increments after the fourth byte and wraps from 511 to 0.
- R5: While load-enable (control bit 0) is 0, window writes do not change the memory, the address or the byte index. Window reads return 0 and advance nothing.
- R6: Control bit 1 drives `seq_pc_rst` from the cycle after the write. The control register reads back as {6'b0, bit1, bit0}.
- R7: A write to either address register returns the byte index to 0 and discards any bytes staged for a partial word.
- R8: With loading enabled, window reads return the bytes of the addressed word least significant first. The address advances after the fourth read.
- R9: In the cycle of a fourth-byte write, the fetch port still returns the old word at that address. From the next cycle it returns the new word.
- R10: The first three bytes of a word leave the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 control, 1 data window, 2 address low, 3 address high |
| host_wr | input | 1 | Write strobe; takes priority over host_rd |
| host_rd | input | 1 | Read strobe (advances the window when selected) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register, valid in the strobe cycle |
| fetch_addr | input | 9 | Sequencer fetch word address |
| fetch_word | output | 32 | Stored word at fetch_addr |
| seq_pc_rst | output | 1 | Program counter reset level (control bit 1) |

## Verification
Two actions can land in the same cycle. The host can commit a word through its fourth byte while the sequencer fetch port is reading that same word. To provoke this, the bench holds `fetch_addr` on the target word while it issues the final byte write. It samples the fetch output inside the commit cycle and expects the previous word. It samples again after the edge and expects the newly assembled word. The same commit also moves the address, so the bench reads the low address register right after the commit to confirm the increment in the same cycle.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_WIN     = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic pc_rst;
        logic load_en;
    } ctrl_t;

    typedef struct packed {
        logic ctrl_wr;
        logic lo_wr;
        logic hi_wr;
        logic win_wr;
        logic win_rd;
    } host_op_t;

    // A write wins over a read presented in the same cycle.
    function automatic host_op_t decode_op(input logic [1:0] sel,
                                           input logic wr,
                                           input logic rd);
        host_op_t op;
        op.ctrl_wr = wr && (host_sel_e'(sel) == SEL_CTRL);
        op.lo_wr   = wr && (host_sel_e'(sel) == SEL_ADDR_LO);
        op.hi_wr   = wr && (host_sel_e'(sel) == SEL_ADDR_HI);
        op.win_wr  = wr && (host_sel_e'(sel) == SEL_WIN);
        op.win_rd  = rd && !wr && (host_sel_e'(sel) == SEL_WIN);
        return op;
    endfunction

endpackage

// File: rtl/seqram_regs.sv
module seqram_regs
    import seqram_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          op,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              win_step,
    output logic              word_end
);

    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    assign win_step = (op.win_wr || op.win_rd) && ctrl.load_en;
    assign word_end = win_step && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            addr <= '0;
            idx  <= '0;
        end else begin
            if (op.ctrl_wr) begin
                ctrl <= '{pc_rst: wdata[1], load_en: wdata[0]};
            end
            if (op.lo_wr) begin
                addr[BYTE_W-1:0] <= wdata;
                idx              <= '0;
            end else if (op.hi_wr) begin
                addr[ADDR_W-1:BYTE_W] <= wdata[HI_W-1:0];
                idx                   <= '0;
            end else if (word_end) begin
                addr <= addr + ADDR_W'(1);
                idx  <= '0;
            end else if (win_step) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // R4
    mid_word_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (win_step && (idx != LAST_IDX)) |=> (addr == $past(addr)));

    // R4
    addr_move_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |-> $past(word_end || op.lo_wr || op.hi_wr));

    // R7
    addr_wr_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (op.lo_wr || op.hi_wr) |=> (idx == '0));

    // R5
    locked_win_chk: assert property (@(posedge clk) disable iff (rst)
        ((op.win_wr || op.win_rd) && !ctrl.load_en) |=> ($stable(addr) && $stable(idx)));

    // R6
    pc_rst_level_chk: assert property (@(posedge clk) disable iff (rst)
        op.ctrl_wr |=> (ctrl.pc_rst == $past(wdata[1])));

endmodule

// File: rtl/seqram_word_asm.sv
module seqram_word_asm
    import seqram_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
    localparam int WORD_W    = WORD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lane_wr,
    input  logic              flush,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    assign commit = lane_wr && (idx == LAST_IDX);

    // Lanes below the top one are staged; the top lane comes straight from the bus.
    for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                lane_q <= '0;
            end else if (lane_wr && (idx == IDX_W'(g))) begin
                lane_q <= wdata;
            end
        end
        assign commit_word[g*BYTE_W +: BYTE_W] = lane_q;
    end

    assign commit_word[WORD_W-1 -: BYTE_W] = wdata;

endmodule

// File: rtl/seqram_store.sv
module seqram_store #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [WORD_W-1:0] rd_b_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

    // R3
    store_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/seqram_loader.sv
module seqram_loader
    import seqram_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
    localparam int WORD_W    = WORD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_word,
    output logic              seq_pc_rst
);

    host_op_t          op;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic              win_step;
    logic              word_end;
    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] win_word;

    assign op = decode_op(host_sel, host_wr, host_rd);

    seqram_regs #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (host_wdata),
        .ctrl     (ctrl),
        .addr     (addr),
        .idx      (idx),
        .win_step (win_step),
        .word_end (word_end)
    );

    seqram_word_asm #(.WORD_BYTES(WORD_BYTES)) asm_i (
        .clk         (clk),
        .rst         (rst),
        .lane_wr     (op.win_wr && ctrl.load_en),
        .flush       (op.lo_wr || op.hi_wr),
        .idx         (idx),
        .wdata       (host_wdata),
        .commit      (commit),
        .commit_word (commit_word)
    );

    seqram_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (commit),
        .wr_addr   (addr),
        .wr_data   (commit_word),
        .rd_a_addr (addr),
        .rd_a_data (win_word),
        .rd_b_addr (fetch_addr),
        .rd_b_data (fetch_word)
    );

    always_comb begin
        case (host_sel_e'(host_sel))
            SEL_CTRL:    host_rdata = {6'b0, ctrl.pc_rst, ctrl.load_en};
            SEL_WIN:     host_rdata = ctrl.load_en ? win_word[idx*BYTE_W +: BYTE_W] : '0;
            SEL_ADDR_LO: host_rdata = addr[BYTE_W-1:0];
            SEL_ADDR_HI: host_rdata = BYTE_W'(addr[ADDR_W-1:BYTE_W]);
            default:     host_rdata = '0;
        endcase
    end

    assign seq_pc_rst = ctrl.pc_rst;

    // R4
    commit_at_word_end_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> word_end);

endmodule

// File: tb/seqram_loader_tb_top.sv
`timescale 1ns/1ps
module seqram_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [8:0]  fetch_addr = '0;
    logic [31:0] fetch_word;
    logic        seq_pc_rst;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [512];

    always #10 clk = ~clk;

    seqram_loader dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .seq_pc_rst (seq_pc_rst)
    );

    function automatic logic [8:0] next_addr(input logic [8:0] a);
        return a + 9'd1;
    endfunction

    function automatic logic [7:0] lane_of(input logic [31:0] w, input int i);
        return w[i*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        host_sel = s; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [8:0] a);
        wr(2'd3, {7'b0, a[8]});
        wr(2'd2, a[7:0]);
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) wr(2'd1, lane_of(w, i));
    endtask

    task automatic fetch_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        fetch_addr = a;
        #1 check(req, fetch_word, exp);
    endtask

    task automatic reg_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
        logic [7:0] v;
        rd(s, v);
        check(req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [31:0] wa, wb, wc, wd, we;
        logic [8:0]  addrs [48];

        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_chk("R1 ctrl", 2'd0, 8'h00);
        reg_chk("R1 addr lo", 2'd2, 8'h00);
        reg_chk("R1 addr hi", 2'd3, 8'h00);
        check("R1 pc reset", {31'd0, seq_pc_rst}, 32'd0);

        // R6 control bits and program counter reset level
        wr(2'd0, 8'h02);
        check("R6 pc reset set", {31'd0, seq_pc_rst}, 32'd1);
        reg_chk("R6 ctrl readback", 2'd0, 8'h02);
        wr(2'd0, 8'hFD);
        check("R6 pc reset clear", {31'd0, seq_pc_rst}, 32'd0);
        reg_chk("R6 ctrl upper bits zero", 2'd0, 8'h01);

        // R2 address composition
        wr(2'd3, 8'hFF);
        reg_chk("R2 hi readback", 2'd3, 8'h01);
        wr(2'd2, 8'h34);
        wa = 32'hA1B2C3D4;
        put_word(wa);
        fetch_chk("R2 R3 word at 0x134", 9'h134, wa);
        reg_chk("R4 lo after word", 2'd2, 8'h35);
        reg_chk("R2 hi after word", 2'd3, 8'h01);

        // R10 partial word, R9 commit against fetch
        wb = 32'h55667788;
        set_addr(9'h134);
        for (int i = 0; i < 3; i++) wr(2'd1, lane_of(wb, i));
        fetch_chk("R10 partial keeps old", 9'h134, wa);
        reg_chk("R4 lo mid word", 2'd2, 8'h34);
        fetch_addr = 9'h134;
        host_sel = 2'd1; host_wdata = lane_of(wb, 3); host_wr = 1'b1;
        #1 check("R9 old word in commit cycle", fetch_word, wa);
        @(negedge clk);
        host_wr = 1'b0;
        #1 check("R9 R3 new word after commit", fetch_word, wb);
        reg_chk("R4 lo after commit", 2'd2, 8'h35);

        // R8 window readback order
        set_addr(9'h134);
        for (int i = 0; i < 4; i++) begin
            rd(2'd1, v);
            check("R8 readback byte", {24'd0, v}, {24'd0, lane_of(wb, i)});
            if (i == 2) reg_chk("R8 lo before fourth read", 2'd2, 8'h34);
        end
        reg_chk("R8 lo after fourth read", 2'd2, 8'h35);

        // R7 address write resets index and drops staged bytes
        set_addr(9'h010);
        wr(2'd1, 8'hEE);
        wr(2'd1, 8'hEE);
        set_addr(9'h010);
        wc = 32'h01020304;
        put_word(wc);
        fetch_chk("R7 realigned write", 9'h010, wc);
        reg_chk("R7 lo after word", 2'd2, 8'h11);
        set_addr(9'h134);
        rd(2'd1, v);
        rd(2'd1, v);
        wr(2'd2, 8'h34);
        rd(2'd1, v);
        check("R7 read index reset", {24'd0, v}, {24'd0, lane_of(wb, 0)});

        // R5 window locked
        wr(2'd0, 8'h00);
        set_addr(9'h010);
        put_word(32'hDEADBEEF);
        fetch_chk("R5 locked write ignored", 9'h010, wc);
        reg_chk("R5 lo unchanged by writes", 2'd2, 8'h10);
        rd(2'd1, v);
        check("R5 locked read zero", {24'd0, v}, 32'd0);
        for (int i = 0; i < 3; i++) rd(2'd1, v);
        reg_chk("R5 lo unchanged by reads", 2'd2, 8'h10);
        wr(2'd0, 8'h01);
        wd = 32'h0A0B0C0D;
        put_word(wd);
        fetch_chk("R5 index untouched while locked", 9'h010, wd);

        // R4 wrap
        set_addr(9'h1FF);
        we = 32'hCAFEF00D;
        put_word(we);
        reg_chk("R4 wrap lo", 2'd2, 8'h00);
        reg_chk("R4 wrap hi", 2'd3, 8'h00);
        fetch_chk("R4 R3 word at 0x1FF", 9'h1FF, we);

        // R3 R8 random words
        for (int n = 0; n < 48; n++) begin
            logic [8:0]  a;
            logic [31:0] w;
            a = 9'($urandom % 512);
            w = $urandom;
            addrs[n] = a;
            model[a] = w;
            set_addr(a);
            put_word(w);
            reg_chk("R4 random lo step", 2'd2, lane_of({23'd0, next_addr(a)}, 0));
        end
        for (int n = 0; n < 48; n++) begin
            fetch_chk("R3 random fetch", addrs[n], model[addrs[n]]);
            if (n % 4 == 0) begin
                set_addr(addrs[n]);
                for (int i = 0; i < 4; i++) begin
                    rd(2'd1, v);
                    check("R8 random readback", {24'd0, v}, {24'd0, lane_of(model[addrs[n]], i)});
                end
            end
        end

        finish_run();
    end

endmodule